// File: doc/BRIEF.md
# Descriptor-List DMA Channel Engine

This block is a single memory-to-memory copy channel driven by a two-level list in memory. Software writes one command word holding the address of a list of 32-bit pointers. Each pointer names an array of four-word copy descriptors. The channel fetches each pointer, then each descriptor in that pointer's array. It copies the requested number of 32-bit words from source to destination over a word-wide memory port with a request/acknowledge handshake. It then moves to the next pointer until the pointer flagged as last has been handled.

Outcomes are reported as result words in a small FIFO. Software pops that FIFO by reading a register. A status register, a configuration register and a read-to-clear interrupt status register complete the register set. The interrupt status register holds one bit per channel in a wider system, and this channel owns the bit at its own index.

Register access is a plain strobe bus. A request is taken on the clock edge where `reg_req` is high. Read data is combinational from the address, and any read side effect (popping the FIFO or clearing the interrupt) is applied at that edge. Word register addresses are: 0 command, 1 result, 2 abort, 3 status, 4 config, 5 interrupt status.

Top module: `dlm_channel`

## Requirements
- R1: A write to address 0 whose bits 31:29 equal 1 starts a walk of the pointer list at byte address {bits 28:0, 3'b000}. While the walk runs, status bit 0 (ready) reads 0 and status bits 28:27 read 1. When idle, these read 1 and 0 respectively.
- R2: Each pointer entry gives its descriptor array at byte address {bits 28:0, 3'b000}. Bit 31 set means it is the final pointer. Pointers are fetched from consecutive words.
- R3: A descriptor is four consecutive words: command, source, destination, byte length. The channel copies ceil(length/4) words in ascending address order, one read followed by one write per word. Words past that count are left untouched.
- R4: A descriptor of length 0 makes no memory access beyond its own four fetches.
- R5: Command bit 31 ends the descriptor array. When the final pointer's final descriptor completes, a done result 0x80000002 is posted only if config bit 2 is set. The channel then returns to ready.
- R6: Results go into a 4-deep FIFO. Reading address 1 pops the oldest entry. A read of an empty FIFO returns 0. A result that arrives while the FIFO is full is dropped. Status bit 1 shows a waiting result, and status bits 31:29 give the count.
- R7: A command form other than 1, or a descriptor mode (command bits 1:0) other than 0, posts the error result 0x80000008 regardless of config. After that the channel stays not ready and ignores command writes until reset.
- R8: A command write while a walk is running is ignored.
- R9: Writing 0 to address 2 during a walk aborts it and returns the channel to ready. It posts 0x80000004 only if config bit 1 is set. Writing a nonzero value to address 2 has no effect.
- R10: Config bit 0 enables the interrupt. Each result accepted into the FIFO while bit 0 is set raises bit CH_INDEX of the interrupt status register (address 5) and the `irq` pin. Reading address 5 clears both.
- R11: After reset the channel is ready, the FIFO is empty, config and interrupt status are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds a two-pointer list with an odd byte length, a zero-length descriptor and an unused word after each copy. It counts every memory acknowledge. A design that truncated rather than rounded the length would leave a word uncopied. A design that touched memory for a zero length, or read a word too many, would give a different access count. Other tests fill the result FIFO past its depth, write a command during a walk, abort both with a zero and with a nonzero value, and check each config bit on its own. A design that overwrote the FIFO head, honoured a busy command write, or posted results that config disabled would leave the wrong queue of results. The error cases then send a valid command into a halted channel. They also repeat the check after reset with a bad command form, which catches a halt that is not sticky.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
   localparam logic [2:0] RA_CMD   = 3'd0;
   localparam logic [2:0] RA_RSLT  = 3'd1;
   localparam logic [2:0] RA_ABORT = 3'd2;
   localparam logic [2:0] RA_STAT  = 3'd3;
   localparam logic [2:0] RA_CFG   = 3'd4;
   localparam logic [2:0] RA_IRQ   = 3'd5;

   localparam int FL_ERR  = 3;
   localparam int FL_FLSH = 2;
   localparam int FL_DONE = 1;

   localparam int CF_IRQ  = 0;
   localparam int CF_FLSH = 1;
   localparam int CF_DONE = 2;

   typedef enum logic [2:0] {
      W_IDLE, W_PTR, W_DESC, W_RD, W_WR, W_HALT
   } wstate_t;
endpackage

// File: rtl/dlm_rfifo.sv
module dlm_rfifo #(
   parameter int DW    = 4,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   logic [DW-1:0] slots [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          full, empty, do_push, do_pop;

   initial begin
      assert (DEPTH >= 1 && DEPTH <= 7) else $fatal(1, "DEPTH must fit a 3-bit count");
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slots[rp];

   function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         count <= '0;
      end else begin
         if (do_push) begin
            slots[wp] <= din;
            wp <= wrap_inc(wp);
         end
         if (do_pop) rp <= wrap_inc(rp);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (count == '0));
   assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/dlm_walker.sv
module dlm_walker
   import dlm_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [31:0] cmd_word,
   input  logic        abort,
   output logic        ready,
   output logic        busy,
   output logic        post,
   output logic [3:0]  post_flags,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack
);
   localparam int WCW = LEN_W - 1;

   initial begin
      assert (LEN_W >= 3 && LEN_W <= 32) else $fatal(1, "LEN_W out of range");
   end

   wstate_t        st, fin_st;
   logic [31:0]    ptr_a, dsc_a, src_a, dst_a, wbuf;
   logic           ptr_last, dcmd_last, fin_done;
   logic [1:0]     dmode, widx;
   logic [WCW-1:0] wleft, words;
   logic [LEN_W:0] len_up;

   assign len_up   = {1'b0, mem_rdata[LEN_W-1:0]} + (LEN_W+1)'(3);
   assign words    = len_up[LEN_W:2];
   assign fin_st   = dcmd_last ? (ptr_last ? W_IDLE : W_PTR) : W_DESC;
   assign fin_done = dcmd_last && ptr_last;

   assign ready     = (st == W_IDLE);
   assign busy      = (st == W_PTR) || (st == W_DESC) || (st == W_RD) || (st == W_WR);
   assign mem_req   = busy;
   assign mem_we    = (st == W_WR);
   assign mem_wdata = wbuf;
   always_comb begin
      unique case (st)
         W_PTR:   mem_addr = ptr_a;
         W_DESC:  mem_addr = dsc_a;
         W_RD:    mem_addr = src_a;
         W_WR:    mem_addr = dst_a;
         default: mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= W_IDLE;
         post <= 1'b0;
         post_flags <= '0;
         ptr_a <= '0; dsc_a <= '0; src_a <= '0; dst_a <= '0; wbuf <= '0;
         ptr_last <= 1'b0; dcmd_last <= 1'b0; dmode <= '0; widx <= '0; wleft <= '0;
      end else begin
         post <= 1'b0;
         post_flags <= '0;
         if (abort && busy) begin
            st <= W_IDLE;
            post <= 1'b1;
            post_flags[FL_FLSH] <= 1'b1;
         end else begin
            unique case (st)
               W_IDLE: if (start) begin
                  if (cmd_word[31:29] == 3'd1) begin
                     ptr_a <= {cmd_word[28:0], 3'b000};
                     st <= W_PTR;
                  end else begin
                     post <= 1'b1;
                     post_flags[FL_ERR] <= 1'b1;
                     st <= W_HALT;
                  end
               end
               W_PTR: if (mem_ack) begin
                  dsc_a <= {mem_rdata[28:0], 3'b000};
                  ptr_last <= mem_rdata[31];
                  ptr_a <= ptr_a + 32'd4;
                  widx <= '0;
                  st <= W_DESC;
               end
               W_DESC: if (mem_ack) begin
                  dsc_a <= dsc_a + 32'd4;
                  widx <= widx + 2'd1;
                  unique case (widx)
                     2'd0: begin dcmd_last <= mem_rdata[31]; dmode <= mem_rdata[1:0]; end
                     2'd1: src_a <= mem_rdata;
                     2'd2: dst_a <= mem_rdata;
                     default: begin
                        if (dmode != 2'd0) begin
                           post <= 1'b1;
                           post_flags[FL_ERR] <= 1'b1;
                           st <= W_HALT;
                        end else if (words == '0) begin
                           st <= fin_st;
                           post <= fin_done;
                           post_flags[FL_DONE] <= fin_done;
                        end else begin
                           wleft <= words;
                           st <= W_RD;
                        end
                     end
                  endcase
               end
               W_RD: if (mem_ack) begin
                  wbuf <= mem_rdata;
                  src_a <= src_a + 32'd4;
                  st <= W_WR;
               end
               W_WR: if (mem_ack) begin
                  dst_a <= dst_a + 32'd4;
                  wleft <= wleft - 1'b1;
                  if (wleft == WCW'(1)) begin
                     st <= fin_st;
                     post <= fin_done;
                     post_flags[FL_DONE] <= fin_done;
                     widx <= '0;
                  end else begin
                     st <= W_RD;
                  end
               end
               default: st <= W_HALT;
            endcase
         end
      end
   end

   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_HALT) |=> (st == W_HALT));
   assert_start_leaves_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && start) |=> !ready);
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));
   assert_abort_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && busy) |=> (ready && post && post_flags[FL_FLSH]));
endmodule

// File: rtl/dlm_channel.sv
module dlm_channel
   import dlm_pkg::*;
#(
   parameter int CH_INDEX = 3,
   parameter int NUM_CH   = 16,
   parameter int RDEPTH   = 4,
   parameter int LEN_W    = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_req,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack,
   output logic        irq
);
   localparam int CW = $clog2(RDEPTH + 1);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 32 && CH_INDEX < NUM_CH) else $fatal(1, "bad channel index");
   end

   logic          wr_cmd, wr_abort, rd_rslt, rd_irq;
   logic          ready, busy, post, push;
   logic [3:0]    post_flags, head;
   logic [CW-1:0] count;
   logic [2:0]    cfg;
   logic          irq_q;
   logic [31:0]   irq_vec;

   assign wr_cmd   = reg_req && reg_we && (reg_addr == RA_CMD);
   assign wr_abort = reg_req && reg_we && (reg_addr == RA_ABORT) && (reg_wdata == '0);
   assign rd_rslt  = reg_req && !reg_we && (reg_addr == RA_RSLT);
   assign rd_irq   = reg_req && !reg_we && (reg_addr == RA_IRQ);

   dlm_walker #(.LEN_W(LEN_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(wr_cmd), .cmd_word(reg_wdata), .abort(wr_abort),
      .ready(ready), .busy(busy), .post(post), .post_flags(post_flags),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   assign push = post && (post_flags[FL_ERR]
                       || (post_flags[FL_FLSH] && cfg[CF_FLSH])
                       || (post_flags[FL_DONE] && cfg[CF_DONE]));

   dlm_rfifo #(.DW(4), .DEPTH(RDEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(post_flags),
      .pop(rd_rslt), .head(head), .count(count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
         irq_q <= 1'b0;
      end else begin
         if (reg_req && reg_we && (reg_addr == RA_CFG)) cfg <= reg_wdata[2:0];
         if (push && cfg[CF_IRQ]) irq_q <= 1'b1;
         else if (rd_irq) irq_q <= 1'b0;
      end
   end

   assign irq     = irq_q;
   assign irq_vec = 32'(irq_q) << CH_INDEX;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_RSLT: if (count != '0) reg_rdata = {1'b1, 27'd0, head};
         RA_STAT: begin
            reg_rdata[0]     = ready;
            reg_rdata[1]     = (count != '0);
            reg_rdata[28:27] = {1'b0, busy};
            reg_rdata[31:29] = 3'(count);
         end
         RA_CFG:  reg_rdata[2:0] = cfg;
         RA_IRQ:  reg_rdata = irq_vec;
         default: reg_rdata = '0;
      endcase
   end

   assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_irq && !push) |=> !irq);
   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !(push && cfg[CF_IRQ])) |=> !irq);
   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_cmd && !wr_abort && !mem_ack) |=> busy);
endmodule

// File: tb/dlm_channel_tb.sv
module dlm_channel_tb;
   localparam int CH = 3;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_req = 1'b0, reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req, mem_we, mem_ack = 1'b0, irq;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

   always #2.5 clk = ~clk;

   dlm_channel #(.CH_INDEX(CH)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .irq(irq)
   );

   // bench-owned memory, 8 KB; preload via poke port
   logic [31:0] mem [2048];
   logic        pk_en = 1'b0;
   logic [31:0] pk_addr = '0, pk_data = '0;
   int          acc_cnt = 0;
   always @(posedge clk) begin
      if (pk_en) mem[pk_addr[12:2]] <= pk_data;
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         acc_cnt <= acc_cnt + 1;
         if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
         else mem_rdata <= mem[mem_addr[12:2]];
      end
   end

   int total = 0, bad = 0;
   logic [31:0] exp_q [$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); pk_en = 1'b1; pk_addr = a; pk_data = d;
      @(negedge clk); pk_en = 1'b0;
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] l);
      poke(a, c); poke(a + 4, s); poke(a + 8, d); poke(a + 12, l);
   endtask

   task automatic rwr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rrd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_req = 1'b0;
   endtask

   task automatic wait_ready();
      logic [31:0] s;
      int n = 0;
      do begin rrd(3'd3, s); n++; end while (!s[0] && n < 2000);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
   endtask

   function automatic logic [31:0] lst(input logic [31:0] a);
      return {3'b001, a[31:3]};
   endfunction

   // scoreboard monitor: pops the DUT FIFO and compares with expected queue
   task automatic drain(input string tag);
      logic [31:0] s, r;
      for (int i = 0; i < 8; i++) begin
         rrd(3'd3, s);
         if (s[1]) begin
            rrd(3'd1, r);
            if (exp_q.size() == 0) check({tag, " unexpected result"}, r, 32'd0);
            else check(tag, r, exp_q.pop_front());
         end
      end
      check({tag, " queue empty"}, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog timeout");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int a0;
      for (int i = 0; i < 64; i++) poke(32'h1000 + 4*i, 32'hA500_0000 + i);
      for (int i = 0; i < 16; i++) poke(32'h1800 + 4*i, 32'hDEAD_0000 + i);
      poke(32'h1E00, 32'h0BAD_0001);
      // list A: two pointers
      poke(32'h100, 32'h0000_0040);
      poke(32'h104, 32'h8000_0060);
      put_desc(32'h200, 32'h0,         32'h1000, 32'h1800, 32'd8);
      put_desc(32'h210, 32'h8000_0000, 32'h1010, 32'h1810, 32'd5);
      put_desc(32'h300, 32'h0,         32'h1020, 32'h1820, 32'd0);
      put_desc(32'h310, 32'h8000_0000, 32'h1030, 32'h1830, 32'd4);
      // long list
      poke(32'h180, 32'h8000_0080);
      put_desc(32'h400, 32'h8000_0000, 32'h1000, 32'h1C00, 32'd64);
      // short list into 0x1E00
      poke(32'h1A0, 32'h8000_00A0);
      put_desc(32'h500, 32'h8000_0000, 32'h1000, 32'h1E00, 32'd4);
      // bad-mode list
      poke(32'h1C0, 32'h8000_00C0);
      put_desc(32'h600, 32'h8000_0001, 32'h1000, 32'h1E00, 32'd4);
      do_reset();

      // R11 reset state
      rrd(3'd3, v); check("R11 status after reset", v, 32'h1);
      rrd(3'd4, v); check("R11 config after reset", v, 32'h0);
      check("R11 irq after reset", 32'(irq), 32'd0);
      rrd(3'd1, v); check("R6 empty read", v, 32'h0);

      // R1 R2 R3 R4 R5 two-level walk
      rwr(3'd4, 32'h7);
      a0 = acc_cnt;
      rwr(3'd0, lst(32'h100));
      rrd(3'd3, v); check("R1 busy status", v & 32'h1800_0001, 32'h0800_0000);
      wait_ready();
      exp_q.push_back(32'h8000_0002);
      check("R4 access count", 32'(acc_cnt - a0), 32'd28);
      check("R3 word0", mem[32'h1800 >> 2], 32'hA500_0000);
      check("R3 word1", mem[32'h1804 >> 2], 32'hA500_0001);
      check("R3 rounded word", mem[32'h1814 >> 2], 32'hA500_0005);
      check("R3 past length", mem[32'h1818 >> 2], 32'hDEAD_0006);
      check("R4 zero length dst", mem[32'h1820 >> 2], 32'hDEAD_0008);
      check("R2 second pointer", mem[32'h1830 >> 2], 32'hA500_000C);
      check("R10 irq pin", 32'(irq), 32'd1);
      rrd(3'd3, v); check("R6 status count", v, 32'h2000_0003);
      drain("R5 done result");
      rrd(3'd5, v); check("R10 irq status bit", v, 32'h1 << CH);
      rrd(3'd5, v); check("R10 irq cleared", v, 32'h0);
      check("R10 irq pin low", 32'(irq), 32'd0);

      // R8 command while busy ignored
      rwr(3'd0, lst(32'h180));
      rwr(3'd0, lst(32'h1A0));
      wait_ready();
      exp_q.push_back(32'h8000_0002);
      check("R8 second cmd ignored", mem[32'h1E00 >> 2], 32'h0BAD_0001);
      check("R3 long copy end", mem[32'h1C3C >> 2], 32'hA500_000F);
      drain("R8 single result");

      // R9 abort with flush result
      rwr(3'd4, 32'h3);
      rwr(3'd0, lst(32'h180));
      repeat (10) @(negedge clk);
      rwr(3'd2, 32'h0);
      rrd(3'd3, v); check("R9 ready after abort", v & 32'h1, 32'h1);
      exp_q.push_back(32'h8000_0004);
      drain("R9 flush result");
      // R9 nonzero abort write has no effect
      rwr(3'd4, 32'h7);
      rwr(3'd0, lst(32'h180));
      repeat (6) @(negedge clk);
      rwr(3'd2, 32'h1);
      rrd(3'd3, v); check("R9 nonzero abort ignored", v & 32'h1, 32'h0);
      wait_ready();
      exp_q.push_back(32'h8000_0002);
      drain("R9 completes after nonzero");
      // R9 abort without flush result
      rwr(3'd4, 32'h5);
      rwr(3'd0, lst(32'h180));
      repeat (6) @(negedge clk);
      rwr(3'd2, 32'h0);
      repeat (3) @(negedge clk);
      rrd(3'd3, v); check("R9 no flush result", v, 32'h1);

      // R5 done suppressed
      rwr(3'd4, 32'h3);
      rrd(3'd5, v);
      rwr(3'd0, lst(32'h100));
      wait_ready();
      rrd(3'd3, v); check("R5 no done result", v, 32'h1);
      check("R10 no irq without result", 32'(irq), 32'd0);

      // R6 overflow
      rwr(3'd4, 32'h4);
      for (int k = 0; k < 5; k++) begin
         rwr(3'd0, lst(32'h100));
         wait_ready();
      end
      rrd(3'd3, v); check("R6 full count", v, 32'h8000_0003);
      check("R10 irq disabled", 32'(irq), 32'd0);
      for (int k = 0; k < 4; k++) exp_q.push_back(32'h8000_0002);
      drain("R6 overflow drop");
      rrd(3'd1, v); check("R6 empty after drain", v, 32'h0);

      // R7 bad descriptor mode
      poke(32'h1E00, 32'h0BAD_0001);
      rwr(3'd0, lst(32'h1C0));
      repeat (30) @(negedge clk);
      exp_q.push_back(32'h8000_0008);
      drain("R7 mode error");
      rwr(3'd0, lst(32'h1A0));
      repeat (30) @(negedge clk);
      rrd(3'd3, v); check("R7 halted not ready", v, 32'h0);
      check("R7 cmd ignored when halted", mem[32'h1E00 >> 2], 32'h0BAD_0001);

      // R11 reset recovers, R7 bad form
      do_reset();
      rrd(3'd3, v); check("R11 ready after reset", v, 32'h1);
      rwr(3'd0, 32'h4000_0020);
      repeat (3) @(negedge clk);
      exp_q.push_back(32'h8000_0008);
      drain("R7 form error");
      rrd(3'd3, v); check("R7 form halts", v & 32'h1, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule